// File: doc/BRIEF.md
# Programmable-Rate Symbol Error Injector

This block sits in a byte-wide symbol stream, between the interleaving and de-interleaving stages of a forward-error-correction test path. It deliberately corrupts symbols so that the decoder downstream has errors to correct. The probability that a given symbol is corrupted comes from a ladder of 26 settings. Setting n, for n from 1 to 25, corrupts a symbol with probability 2^-n, so setting 1 gives one half and setting 25 gives roughly 3e-8. Setting 26 turns injection off completely. The bit error rate shown to a user is this symbol probability divided by 8.

Two debounced pulse inputs move the setting while the system is in setup, before a run starts. One pulse makes errors more frequent and the other makes them less frequent. The stream is framed in codewords of 204 symbols. Each symbol that is corrupted produces a one-cycle strobe, together with the bit mask that was applied and the symbol's index within its codeword, so that external counters can tally the injected errors.

Top module: `symbol_err_injector`

## Requirements
- R1: After reset the setting is 26, and out_valid and inj_strobe are low.
- R2: A rate_up pulse in setup moves the setting one step toward 1. At setting 1 it has no effect.
- R3: A rate_down pulse in setup moves the setting one step toward 26. At setting 26 it has no effect.
- R4: The setting does not change when setup_mode is low, or when rate_up and rate_down are high in the same cycle.
- R5: A 32-bit Galois LFSR shifts left with feedback mask 0x00400007 (polynomial x^32+x^22+x^2+x+1). It starts at the SEED value after reset and advances once per cycle in which in_valid is high, and only in those cycles.
- R6: A valid symbol is chosen for corruption when the setting n is 25 or less and LFSR bits [n-1:0] are all zero, with the LFSR value taken before it advances. At setting 26 no symbol is ever chosen.
- R7: A chosen symbol is XORed with LFSR bits [31:24]. If those bits are zero, the mask 0x01 is used instead, so a chosen symbol always changes. inj_mask carries the mask that was applied.
- R8: out_valid follows in_valid one cycle later. A symbol that is not chosen appears on out_data unchanged, one cycle after it is presented.
- R9: inj_strobe is high for exactly the one output cycle of each chosen symbol, and only while out_valid is high. In that cycle inj_pos holds the symbol's index in its codeword: 0 to 203, counting valid symbols from reset and wrapping from 203 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_mode | input | 1 | High while the setting may be changed |
| rate_up | input | 1 | Debounced pulse; makes errors more frequent |
| rate_down | input | 1 | Debounced pulse; makes errors less frequent |
| in_valid | input | 1 | Input symbol qualifier |
| in_data | input | 8 | Input symbol |
| out_valid | output | 1 | Output symbol qualifier |
| out_data | output | 8 | Output symbol, possibly corrupted |
| inj_strobe | output | 1 | One-cycle pulse for each corrupted symbol |
| inj_mask | output | 8 | Bit mask applied to the corrupted symbol |
| inj_pos | output | 8 | Index of the corrupted symbol in its codeword |
| rate_sel | output | 5 | Current setting, 1 to 26 |

## Verification
The assertions assume that reset is applied before any traffic. They also assume that rate_up and rate_down are single-cycle pulses, so any press that lasts several cycles counts as several steps. The stimulus drives each pulse high for exactly one cycle and then low for at least one cycle. It drives in_valid and in_data only between clock edges and inserts regular idle gaps, so that holding the LFSR on idle cycles is exercised. A scoreboard restates the LFSR, the hit test and the codeword index in its own form and predicts every output symbol.

// File: rtl/sei_pkg.sv
package sei_pkg;
  localparam int SYM_W   = 8;
  localparam int LFSR_W  = 32;
  localparam logic [LFSR_W-1:0] POLY = 32'h0040_0007;
  localparam int NUM_SET = 26;
  localparam int SET_W   = $clog2(NUM_SET + 1);

  // Galois step: shift left, fold the feedback mask in when the top bit leaves
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], 1'b0} ^ (s[LFSR_W-1] ? POLY : '0);
  endfunction

  // Hit when the lowest 'setting' bits are all zero; the last setting never hits
  function automatic logic rate_hit(input logic [LFSR_W-1:0] s,
                                    input logic [SET_W-1:0]  setting);
    logic hit;
    hit = (int'(setting) >= 1) && (int'(setting) < NUM_SET);
    for (int i = 0; i < LFSR_W; i++)
      if (i < int'(setting) && s[i]) hit = 1'b0;
    return hit;
  endfunction

  // Corruption mask from the top bits; never zero
  function automatic logic [SYM_W-1:0] mask_pick(input logic [LFSR_W-1:0] s);
    logic [SYM_W-1:0] m;
    m = s[LFSR_W-1 -: SYM_W];
    return (m == '0) ? SYM_W'(1) : m;
  endfunction
endpackage

// File: rtl/sei_rate_reg.sv
module sei_rate_reg
  import sei_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_mode,
  input  logic             rate_up,
  input  logic             rate_down,
  output logic [SET_W-1:0] rate
);
  localparam logic [SET_W-1:0] TOP_SET = SET_W'(NUM_SET);
  localparam logic [SET_W-1:0] LOW_SET = SET_W'(1);

  logic step_up_w, step_dn_w;
  assign step_up_w = setup_mode && rate_up && !rate_down && (rate > LOW_SET);
  assign step_dn_w = setup_mode && rate_down && !rate_up && (rate < TOP_SET);

  always_ff @(posedge clk) begin
    if (!rst_n)         rate <= TOP_SET;
    else if (step_up_w) rate <= rate - LOW_SET;
    else if (step_dn_w) rate <= rate + LOW_SET;
  end

  p_rate_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate >= LOW_SET) && (rate <= TOP_SET));
  p_hold_outside_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_mode |=> $stable(rate));
  p_both_pressed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_up && rate_down) |=> $stable(rate));
  p_sat_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == LOW_SET && !rate_down) |=> (rate == LOW_SET));
endmodule

// File: rtl/sei_lfsr.sv
module sei_lfsr
  import sei_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= lfsr_step(state);
  end

  p_lfsr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/sei_cw_count.sv
module sei_cw_count #(
  parameter int CW_LEN = 204,
  parameter int IDX_W  = $clog2(CW_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CW_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
  end

  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
  p_idx_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && idx == LAST) |=> (idx == '0));
endmodule

// File: rtl/symbol_err_injector.sv
module symbol_err_injector
  import sei_pkg::*;
#(
  parameter int                CW_LEN = 204,
  parameter logic [LFSR_W-1:0] SEED   = 32'hACE1_2468,
  parameter int                POS_W  = $clog2(CW_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_mode,
  input  logic             rate_up,
  input  logic             rate_down,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             inj_strobe,
  output logic [SYM_W-1:0] inj_mask,
  output logic [POS_W-1:0] inj_pos,
  output logic [SET_W-1:0] rate_sel
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [POS_W-1:0]  idx_q;
  logic              hit_w;
  logic [SYM_W-1:0]  mask_w;

  sei_rate_reg u_rate (
    .clk(clk), .rst_n(rst_n), .setup_mode(setup_mode),
    .rate_up(rate_up), .rate_down(rate_down), .rate(rate_sel));

  sei_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .state(lfsr_q));

  sei_cw_count #(.CW_LEN(CW_LEN), .IDX_W(POS_W)) u_cw (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .idx(idx_q));

  // Decision on the pre-advance LFSR value
  assign hit_w  = in_valid && rate_hit(lfsr_q, rate_sel);
  assign mask_w = hit_w ? mask_pick(lfsr_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      inj_strobe <= 1'b0;
      inj_mask   <= '0;
      inj_pos    <= '0;
    end else begin
      out_valid  <= in_valid;
      inj_strobe <= hit_w;
      inj_mask   <= mask_w;
      if (in_valid) begin
        out_data <= in_data ^ mask_w;
        inj_pos  <= idx_q;
      end
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit_w) |=> (out_data == $past(in_data)));
  p_strobe_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inj_strobe |-> out_valid);
  p_mask_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inj_strobe |-> (inj_mask != '0));
  p_off_setting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rate_sel) == NUM_SET) |=> !inj_strobe);
endmodule

// File: tb/symbol_err_injector_tb.sv
module symbol_err_injector_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       setup_mode = 1'b0, rate_up = 1'b0, rate_down = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, inj_strobe;
  logic [7:0] out_data, inj_mask, inj_pos;
  logic [4:0] rate_sel;

  always #10 clk = ~clk;

  symbol_err_injector u_dut (
    .clk(clk), .rst_n(rst_n), .setup_mode(setup_mode), .rate_up(rate_up),
    .rate_down(rate_down), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .inj_strobe(inj_strobe),
    .inj_mask(inj_mask), .inj_pos(inj_pos), .rate_sel(rate_sel));

  typedef struct packed {
    logic [7:0] data;
    logic       strobe;
    logic [7:0] mask;
    logic [7:0] pos;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0, n_hits = 0;
  logic [31:0] m_lfsr = 32'hACE1_2468;
  int          m_pos = 0;
  int          m_set = 26;
  bit          done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: presents one symbol (or an idle cycle) and predicts its result
  task automatic send(input bit v, input logic [7:0] d);
    exp_t  e;
    bit    hit;
    logic [7:0] m;
    logic [31:0] nx;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    if (v) begin
      hit = (m_set <= 25) && ((m_lfsr & ((32'h1 << m_set) - 32'h1)) == 32'h0);
      m   = m_lfsr[31:24];
      if (m == 8'h00) m = 8'h01;
      e.strobe = hit;
      e.mask   = hit ? m : 8'h00;
      e.data   = d ^ e.mask;
      e.pos    = 8'(m_pos);
      sb.push_back(e);
      nx = m_lfsr << 1;
      if (m_lfsr[31]) nx = nx ^ 32'h0040_0007;
      m_lfsr = nx;
      m_pos  = (m_pos == 203) ? 0 : m_pos + 1;
    end
  endtask

  // Monitor: compares outputs between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (inj_strobe && !out_valid) check(0, "R9 strobe without valid", 1, 0);
      if (out_valid) begin
        exp_t e;
        if (sb.size() == 0) check(0, "R8 unexpected output", 1, 0);
        else begin
          e = sb.pop_front();
          check(out_data == e.data, "R7/R8 data", out_data, e.data);
          check(inj_strobe == e.strobe, "R6 strobe", inj_strobe, e.strobe);
          if (e.strobe) begin
            check(inj_mask == e.mask, "R7 mask", inj_mask, e.mask);
            check(inj_pos == e.pos, "R9 position", inj_pos, e.pos);
          end
          if (inj_strobe) n_hits++;
        end
      end
    end
  end

  task automatic press(input bit up, input bit dn, input bit setup);
    @(negedge clk);
    setup_mode = setup; rate_up = up; rate_down = dn;
    if (setup && up && !dn && m_set > 1)  m_set--;
    if (setup && dn && !up && m_set < 26) m_set++;
    @(negedge clk);
    rate_up = 1'b0; rate_down = 1'b0;
  endtask

  task automatic stream(input int count);
    for (int i = 0; i < count; i++) begin
      if (i % 5 == 4) send(1'b0, 8'h00);
      send(1'b1, 8'($urandom));
    end
    send(1'b0, 8'h00);
    send(1'b0, 8'h00);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rate_sel == 5'd26, "R1 reset setting", rate_sel, 26);
    check(!out_valid && !inj_strobe, "R1 outputs quiet", out_valid, 0);

    n_hits = 0;
    stream(40);
    check(n_hits == 0, "R6 setting 26 injects nothing", n_hits, 0);

    press(1'b0, 1'b1, 1'b1);
    check(rate_sel == 5'd26, "R3 saturate at 26", rate_sel, 26);
    for (int i = 0; i < 24; i++) press(1'b1, 1'b0, 1'b1);
    check(rate_sel == 5'd2, "R2 step toward 1", rate_sel, 2);
    press(1'b1, 1'b0, 1'b1);
    press(1'b1, 1'b0, 1'b1);
    check(rate_sel == 5'd1, "R2 saturate at 1", rate_sel, 1);

    press(1'b0, 1'b1, 1'b0);
    check(rate_sel == 5'd1, "R4 ignored outside setup", rate_sel, 1);
    press(1'b1, 1'b1, 1'b1);
    check(rate_sel == 5'd1, "R4 both pressed ignored", rate_sel, 1);

    n_hits = 0;
    stream(250);
    check(n_hits > 60 && n_hits < 190, "R6 setting 1 about half", n_hits, 125);
    check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);

    press(1'b0, 1'b1, 1'b1);
    press(1'b0, 1'b1, 1'b1);
    check(rate_sel == 5'd3, "R3 step toward 26", rate_sel, 3);
    n_hits = 0;
    stream(160);
    check(n_hits < 60, "R6 setting 3 rarer", n_hits, 20);

    for (int i = 0; i < 23; i++) press(1'b0, 1'b1, 1'b1);
    check(rate_sel == 5'd26, "R3 back to 26", rate_sel, 26);
    n_hits = 0;
    stream(40);
    check(n_hits == 0, "R6 off after run", n_hits, 0);
    check(sb.size() == 0, "R8 scoreboard drained at end", sb.size(), 0);

    done = 1;
    report();
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      report();
    end
  end
endmodule